// File: doc/BRIEF.md
# Seven-Stage In-Order Pipeline Stall and Flush Controller

This block decides, every cycle, whether the front end of a seven-stage in-order pipeline may advance. The stage order is IF1, IF2, ID, EX, MEM1, MEM2, WB: instruction fetch and data access each take two stages. There is no result bypassing, so an instruction in ID that reads a register still being produced further down must wait in ID. The register file is written in the second half of the cycle. A value that WB is writing can therefore be read by ID in that same cycle, and WB never causes a wait.

Branches are compared by the ALU, so a branch outcome is only known when the branch sits in EX. While a branch is in IF1, IF2 or ID the controller stops new fetches. When the branch reaches EX it redirects the PC to the target or to the fall-through address and kills anything in the three front stages. The result is a fixed three-cycle branch penalty. All control outputs are combinational functions of the current stage contents, so the surrounding datapath registers act on them at the next clock edge.

Top module: `ilk7_interlock`

## Requirements
- R1: While `rst_ni` is low, and until the second rising clock edge after it goes high, every output is 0 whatever the inputs are.
- R2: A read-after-write hazard exists when an enabled source slot of the ID instruction holds a nonzero register number equal to the destination of a writer slot that is valid and write-enabled. Source slots are indexed 0 and 1. Writer slot 0 is EX, 1 is MEM1 and 2 is MEM2.
- R3: During a hazard, `hold_if1_o`, `hold_if2_o`, `hold_id_o` and `bubble_ex_o` are 1, and `hold_pc_o` is 1 unless a redirect is issued in the same cycle.
- R4: As the pipeline advances, a consumer is held in ID for 3 cycles when its producer is directly ahead of it, 2 cycles when one instruction lies between them and 1 cycle when two lie between them. Dependence chains add up.
- R5: No hazard arises from register 0, from invalid or non-writing writer slots, from disabled source slots, or from a producer that has reached WB.
- R6: A valid branch in EX (`ex_br_vld_i`) drives `redirect_o` and all three squash outputs to 1 and forces `hold_pc_o` to 0. `redirect_taken_o` equals `ex_br_taken_i` in that cycle and is 0 otherwise. With no branch in EX, squash and redirect outputs are 0.
- R7: A valid branch flagged in `fe_br_i` (bit 0 IF1, bit 1 IF2, bit 2 ID) drives `hold_pc_o` to 1. This means a branch costs exactly 3 fetch cycles, for both the taken and the not-taken case.
- R8: A hazard and a branch resolution in the same cycle are both honoured: the holds, the bubble, the squashes and the redirect are all 1, and `hold_pc_o` is 0.
- R9: With no hazard and no branch in flight, all outputs are 0, so one instruction enters EX per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| id_src_i | input | NSRC*AW | Source register numbers of the ID instruction |
| id_re_i | input | NSRC | Per-source read enables |
| wr_vld_i | input | NWR | Valid bits of EX, MEM1, MEM2 |
| wr_we_i | input | NWR | Write enables of EX, MEM1, MEM2 |
| wr_dst_i | input | NWR*AW | Destination registers of EX, MEM1, MEM2 |
| fe_br_i | input | 3 | Valid branch present in IF1, IF2, ID |
| ex_br_vld_i | input | 1 | Valid branch resolving in EX |
| ex_br_taken_i | input | 1 | Outcome of the branch in EX |
| hold_pc_o | output | 1 | Keep the PC; no new fetch |
| hold_if1_o | output | 1 | Keep IF1 contents |
| hold_if2_o | output | 1 | Keep IF2 contents |
| hold_id_o | output | 1 | Keep ID contents |
| bubble_ex_o | output | 1 | Load an invalid slot into EX |
| squash_if1_o | output | 1 | Invalidate IF1 |
| squash_if2_o | output | 1 | Invalidate IF2 |
| squash_id_o | output | 1 | Invalidate ID |
| redirect_o | output | 1 | Load the PC from the resolved branch |
| redirect_taken_o | output | 1 | Redirect goes to the target rather than the fall-through |

## Verification
Short instruction programs are pushed through a behavioural pipeline model. The dependence distance is varied over one, two, three and four slots, which tells the EX, MEM1 and MEM2 comparisons apart from the WB write-through case. Programs that use register 0, non-writing producers, disabled sources and the second source slot separate the qualifiers of the comparison. A two-step dependence chain shows that stall periods add up. Taken and not-taken branches confirm the fixed fetch penalty and the taken flag. Directed cycles cover reset, the warm-up after reset, and the case of a hazard together with a branch resolution, which ordinary program flow cannot produce.

// File: rtl/ilk7_pkg.sv
package ilk7_pkg;
  localparam int unsigned ILK_REG_AW      = 5;
  localparam int unsigned ILK_NUM_SRC     = 2;
  localparam int unsigned ILK_NUM_WR      = 3;
  localparam int unsigned ILK_NUM_FE      = 3;
  localparam int unsigned ILK_SYNC_STAGES = 2;

  // Bundle of control decisions produced each cycle.
  typedef struct packed {
    logic hold_pc;
    logic hold_fe;
    logic bubble;
    logic squash;
    logic redirect;
    logic taken;
  } ilk_ctl_t;
endpackage

// File: rtl/ilk7_rst_sync.sv
module ilk7_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic live_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign live_o = sync_q[STAGES-1];
endmodule

// File: rtl/ilk7_raw_detect.sv
module ilk7_raw_detect #(
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2,
  parameter int unsigned NWR  = 3
) (
  input  logic [NSRC-1:0][AW-1:0] src_i,
  input  logic [NSRC-1:0]         src_re_i,
  input  logic [NWR-1:0]          wr_vld_i,
  input  logic [NWR-1:0]          wr_we_i,
  input  logic [NWR-1:0][AW-1:0]  wr_dst_i,
  output logic                    hit_o
);
  logic [NSRC-1:0]          src_live;
  logic [NWR-1:0]           wr_live;
  logic [NSRC-1:0][NWR-1:0] match;

  genvar gs, gw;
  generate
    for (gs = 0; gs < NSRC; gs++) begin : g_src
      // Register 0 is hard-wired, so it never carries a dependence.
      assign src_live[gs] = src_re_i[gs] && (src_i[gs] != '0);
    end
    for (gw = 0; gw < NWR; gw++) begin : g_wr
      assign wr_live[gw] = wr_vld_i[gw] && wr_we_i[gw];
    end
    for (gs = 0; gs < NSRC; gs++) begin : g_row
      for (gw = 0; gw < NWR; gw++) begin : g_col
        assign match[gs][gw] = src_live[gs] && wr_live[gw] &&
                               (wr_dst_i[gw] == src_i[gs]);
      end
    end
  endgenerate

  assign hit_o = |match;
endmodule

// File: rtl/ilk7_branch_ctl.sv
module ilk7_branch_ctl #(
  parameter int unsigned NFE = 3
) (
  input  logic [NFE-1:0] fe_br_i,
  input  logic           ex_br_vld_i,
  input  logic           ex_br_taken_i,
  output logic           fetch_block_o,
  output logic           resolve_o,
  output logic           taken_o
);
  // Any branch still ahead of EX stops the fetch of younger slots.
  assign fetch_block_o = |fe_br_i;
  assign resolve_o     = ex_br_vld_i;
  assign taken_o       = ex_br_vld_i && ex_br_taken_i;
endmodule

// File: rtl/ilk7_interlock.sv
module ilk7_interlock
  import ilk7_pkg::*;
#(
  parameter int unsigned AW    = ILK_REG_AW,
  parameter int unsigned NSRC  = ILK_NUM_SRC,
  parameter int unsigned NWR   = ILK_NUM_WR,
  parameter int unsigned NSYNC = ILK_SYNC_STAGES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NSRC-1:0][AW-1:0] id_src_i,
  input  logic [NSRC-1:0]         id_re_i,
  input  logic [NWR-1:0]          wr_vld_i,
  input  logic [NWR-1:0]          wr_we_i,
  input  logic [NWR-1:0][AW-1:0]  wr_dst_i,
  input  logic [ILK_NUM_FE-1:0]   fe_br_i,
  input  logic                    ex_br_vld_i,
  input  logic                    ex_br_taken_i,
  output logic                    hold_pc_o,
  output logic                    hold_if1_o,
  output logic                    hold_if2_o,
  output logic                    hold_id_o,
  output logic                    bubble_ex_o,
  output logic                    squash_if1_o,
  output logic                    squash_if2_o,
  output logic                    squash_id_o,
  output logic                    redirect_o,
  output logic                    redirect_taken_o
);
  logic     live;
  logic     raw_hit;
  logic     fetch_block;
  logic     br_resolve;
  logic     br_taken;
  ilk_ctl_t ctl_d;

  ilk7_rst_sync #(.STAGES(NSYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .live_o (live)
  );

  ilk7_raw_detect #(.AW(AW), .NSRC(NSRC), .NWR(NWR)) u_raw (
    .src_i    (id_src_i),
    .src_re_i (id_re_i),
    .wr_vld_i (wr_vld_i),
    .wr_we_i  (wr_we_i),
    .wr_dst_i (wr_dst_i),
    .hit_o    (raw_hit)
  );

  ilk7_branch_ctl #(.NFE(ILK_NUM_FE)) u_br (
    .fe_br_i       (fe_br_i),
    .ex_br_vld_i   (ex_br_vld_i),
    .ex_br_taken_i (ex_br_taken_i),
    .fetch_block_o (fetch_block),
    .resolve_o     (br_resolve),
    .taken_o       (br_taken)
  );

  always_comb begin
    ctl_d = '0;
    if (live) begin
      ctl_d.hold_fe  = raw_hit;
      ctl_d.bubble   = raw_hit;
      ctl_d.squash   = br_resolve;
      ctl_d.redirect = br_resolve;
      ctl_d.taken    = br_taken;
      // A redirect owns the PC even when the front end is stalled.
      ctl_d.hold_pc  = (raw_hit || fetch_block) && !br_resolve;
    end
  end

  assign hold_pc_o        = ctl_d.hold_pc;
  assign hold_if1_o       = ctl_d.hold_fe;
  assign hold_if2_o       = ctl_d.hold_fe;
  assign hold_id_o        = ctl_d.hold_fe;
  assign bubble_ex_o      = ctl_d.bubble;
  assign squash_if1_o     = ctl_d.squash;
  assign squash_if2_o     = ctl_d.squash;
  assign squash_id_o      = ctl_d.squash;
  assign redirect_o       = ctl_d.redirect;
  assign redirect_taken_o = ctl_d.taken;
endmodule

// File: rtl/ilk7_interlock_chk.sv
module ilk7_interlock_chk #(
  parameter int unsigned NSRC = 2,
  parameter int unsigned NWR  = 3,
  parameter int unsigned NFE  = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            live_i,
  input logic [NSRC-1:0] id_re_i,
  input logic [NWR-1:0]  wr_vld_i,
  input logic [NWR-1:0]  wr_we_i,
  input logic [NFE-1:0]  fe_br_i,
  input logic            ex_br_vld_i,
  input logic            hold_pc_o,
  input logic            hold_if1_o,
  input logic            hold_if2_o,
  input logic            hold_id_o,
  input logic            bubble_ex_o,
  input logic            squash_if1_o,
  input logic            squash_if2_o,
  input logic            squash_id_o,
  input logic            redirect_o,
  input logic            redirect_taken_o
);
  logic any_out;
  assign any_out = hold_pc_o || hold_if1_o || hold_if2_o || hold_id_o ||
                   bubble_ex_o || squash_if1_o || squash_if2_o ||
                   squash_id_o || redirect_o || redirect_taken_o;

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !any_out); // R1
  AST_WARMUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_i |-> !any_out); // R1
  AST_STALL_NEEDS_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_id_o |-> ((|(wr_vld_i & wr_we_i)) && (|id_re_i))); // R2
  AST_STALL_FREEZES_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_id_o && !redirect_o) |-> hold_pc_o); // R3
  AST_NO_WRITER_NO_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(wr_vld_i & wr_we_i)) |-> !bubble_ex_o); // R5
  AST_SQUASH_NEEDS_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_if1_o || squash_if2_o || squash_id_o || redirect_o) |-> ex_br_vld_i); // R6
  AST_REDIRECT_FREES_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> !hold_pc_o); // R6
  AST_TAKEN_NEEDS_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_taken_o |-> redirect_o); // R6
  AST_FRONT_BRANCH_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_i && (|fe_br_i) && !ex_br_vld_i) |-> hold_pc_o); // R7
endmodule

bind ilk7_interlock ilk7_interlock_chk #(
  .NSRC(NSRC), .NWR(NWR), .NFE(ilk7_pkg::ILK_NUM_FE)
) chk_i (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .live_i           (live),
  .id_re_i          (id_re_i),
  .wr_vld_i         (wr_vld_i),
  .wr_we_i          (wr_we_i),
  .fe_br_i          (fe_br_i),
  .ex_br_vld_i      (ex_br_vld_i),
  .hold_pc_o        (hold_pc_o),
  .hold_if1_o       (hold_if1_o),
  .hold_if2_o       (hold_if2_o),
  .hold_id_o        (hold_id_o),
  .bubble_ex_o      (bubble_ex_o),
  .squash_if1_o     (squash_if1_o),
  .squash_if2_o     (squash_if2_o),
  .squash_id_o      (squash_id_o),
  .redirect_o       (redirect_o),
  .redirect_taken_o (redirect_taken_o)
);

// File: tb/ilk7_interlock_tb_top.sv
module ilk7_interlock_tb_top;
  localparam int AW = 5;
  localparam int NSRC = 2;
  localparam int NWR = 3;

  logic clk = 1'b0;
  logic rst_ni;
  logic [NSRC-1:0][AW-1:0] id_src;
  logic [NSRC-1:0] id_re;
  logic [NWR-1:0] wr_vld, wr_we;
  logic [NWR-1:0][AW-1:0] wr_dst;
  logic [2:0] fe_br;
  logic ex_br_vld, ex_br_taken;
  logic hold_pc, hold_if1, hold_if2, hold_id, bubble_ex;
  logic sq_if1, sq_if2, sq_id, redirect, redirect_taken;

  int checks = 0;
  int failures = 0;
  int cnt_hold_id, cnt_hold_pc, cnt_redir, cnt_taken;

  always #5 clk = ~clk;

  ilk7_interlock dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .id_src_i(id_src), .id_re_i(id_re),
    .wr_vld_i(wr_vld), .wr_we_i(wr_we), .wr_dst_i(wr_dst), .fe_br_i(fe_br),
    .ex_br_vld_i(ex_br_vld), .ex_br_taken_i(ex_br_taken),
    .hold_pc_o(hold_pc), .hold_if1_o(hold_if1), .hold_if2_o(hold_if2),
    .hold_id_o(hold_id), .bubble_ex_o(bubble_ex), .squash_if1_o(sq_if1),
    .squash_if2_o(sq_if2), .squash_id_o(sq_id), .redirect_o(redirect),
    .redirect_taken_o(redirect_taken)
  );

  typedef struct {
    bit v; bit we; int dst; bit r0; int s0; bit r1; int s1; bit br; bit tk;
  } ins_t;

  ins_t pl [0:5];   // 0 IF1, 1 IF2, 2 ID, 3 EX, 4 MEM1, 5 MEM2
  ins_t prog [$];

  function automatic ins_t bub();
    ins_t b;
    b = '{default: 0};
    return b;
  endfunction

  function automatic ins_t mk(bit we, int dst, bit r0, int s0, bit r1, int s1,
                              bit br, bit tk);
    ins_t i;
    i = '{v: 1, we: we, dst: dst, r0: r0, s0: s0, r1: r1, s1: s1, br: br, tk: tk};
    return i;
  endfunction

  function automatic ins_t fetch_next();
    if (prog.size() > 0) return prog.pop_front();
    return bub();
  endfunction

  function automatic logic [9:0] got_vec();
    return {hold_pc, hold_if1, hold_if2, hold_id, bubble_ex,
            sq_if1, sq_if2, sq_id, redirect, redirect_taken};
  endfunction

  task automatic check_vec(string tag, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s outputs actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    id_src = '0; id_re = '0; wr_vld = '0; wr_we = '0; wr_dst = '0;
    fe_br = '0; ex_br_vld = 1'b0; ex_br_taken = 1'b0;
  endtask

  task automatic drive_from_model();
    id_src[0] = AW'(pl[2].s0);
    id_src[1] = AW'(pl[2].s1);
    id_re[0]  = pl[2].v && pl[2].r0;
    id_re[1]  = pl[2].v && pl[2].r1;
    for (int k = 0; k < NWR; k++) begin
      wr_vld[k] = pl[3+k].v;
      wr_we[k]  = pl[3+k].we;
      wr_dst[k] = AW'(pl[3+k].dst);
    end
    for (int k = 0; k < 3; k++) fe_br[k] = pl[k].v && pl[k].br;
    ex_br_vld   = pl[3].v && pl[3].br;
    ex_br_taken = pl[3].tk;
  endtask

  // One clock of the reference model; starts and ends just after a rising edge.
  task automatic step_model();
    bit st, fb, rd, tk, hp;
    logic [9:0] exp;
    string tag;
    ins_t nx [0:5];
    drive_from_model();
    st = 0;
    if (pl[2].v) begin
      for (int d = 3; d <= 5; d++) begin
        if (pl[d].v && pl[d].we && pl[d].dst != 0) begin
          if (pl[2].r0 && pl[2].s0 == pl[d].dst) st = 1;
          if (pl[2].r1 && pl[2].s1 == pl[d].dst) st = 1;
        end
      end
    end
    fb = (pl[0].v && pl[0].br) || (pl[1].v && pl[1].br) || (pl[2].v && pl[2].br);
    rd = pl[3].v && pl[3].br;
    tk = rd && pl[3].tk;
    hp = (st || fb) && !rd;
    exp = {hp, st, st, st, st, rd, rd, rd, rd, tk};
    if (st && rd) tag = "R8";
    else if (st) tag = "R3";
    else if (rd) tag = "R6";
    else if (fb) tag = "R7";
    else tag = "R9";
    @(negedge clk);
    check_vec(tag, got_vec(), exp);
    if (hold_id) cnt_hold_id++;
    if (hold_pc) cnt_hold_pc++;
    if (redirect) cnt_redir++;
    if (redirect_taken) cnt_taken++;
    @(posedge clk);
    #1;
    nx[5] = pl[4];
    nx[4] = pl[3];
    nx[3] = (st || rd) ? bub() : pl[2];
    if (rd) begin
      nx[2] = bub(); nx[1] = bub(); nx[0] = fetch_next();
    end else if (st) begin
      nx[2] = pl[2]; nx[1] = pl[1]; nx[0] = pl[0];
    end else begin
      nx[2] = pl[1]; nx[1] = pl[0]; nx[0] = hp ? bub() : fetch_next();
    end
    for (int k = 0; k < 6; k++) pl[k] = nx[k];
  endtask

  task automatic run_prog();
    cnt_hold_id = 0; cnt_hold_pc = 0; cnt_redir = 0; cnt_taken = 0;
    for (int c = 0; c < 18; c++) step_model();
    clear_inputs();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 6; k++) pl[k] = bub();
    rst_ni = 1'b0;
    clear_inputs();
    // Hazard on the inputs throughout reset and warm-up.
    id_src[0] = 5'd1; id_re[0] = 1'b1;
    wr_vld[0] = 1'b1; wr_we[0] = 1'b1; wr_dst[0] = 5'd1;
    ex_br_vld = 1'b1; ex_br_taken = 1'b1; fe_br = 3'b111;
    @(negedge clk);
    check_vec("R1", got_vec(), 10'b0);           // in reset
    #2 rst_ni = 1'b1;
    @(negedge clk);
    check_vec("R1", got_vec(), 10'b0);           // one edge after release
    ex_br_vld = 1'b0; ex_br_taken = 1'b0; fe_br = 3'b000;
    @(negedge clk);
    check_vec("R2", got_vec(), 10'b1111100000);  // live: EX hazard on source slot 0
    @(posedge clk); #1;
    clear_inputs();
    // Directed: MEM2 writer against source slot 1 (R2).
    id_src[1] = 5'd12; id_re[1] = 1'b1;
    wr_vld[2] = 1'b1; wr_we[2] = 1'b1; wr_dst[2] = 5'd12;
    @(negedge clk);
    check_vec("R2", got_vec(), 10'b1111100000);
    @(posedge clk); #1;
    clear_inputs();
    // Directed: hazard and taken resolution in one cycle (R8).
    id_src[0] = 5'd9; id_re[0] = 1'b1;
    wr_vld[1] = 1'b1; wr_we[1] = 1'b1; wr_dst[1] = 5'd9;
    ex_br_vld = 1'b1; ex_br_taken = 1'b1;
    @(negedge clk);
    check_vec("R8", got_vec(), 10'b0111111111);
    @(posedge clk); #1;
    clear_inputs();
    @(negedge clk);
    check_vec("R9", got_vec(), 10'b0);
    @(posedge clk); #1;

    // Producer directly ahead: 3 stall cycles.
    prog.push_back(mk(1, 1, 0, 0, 0, 0, 0, 0));
    prog.push_back(mk(0, 0, 1, 1, 0, 0, 0, 0));
    run_prog();
    check_int("R4", "stall cycles distance 1", cnt_hold_id, 3);

    // One instruction in between, dependence on source slot 1.
    prog.push_back(mk(1, 2, 0, 0, 0, 0, 0, 0));
    prog.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0));
    prog.push_back(mk(0, 0, 0, 0, 1, 2, 0, 0));
    run_prog();
    check_int("R4", "stall cycles distance 2", cnt_hold_id, 2);

    // Two in between.
    prog.push_back(mk(1, 3, 0, 0, 0, 0, 0, 0));
    prog.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0));
    prog.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0));
    prog.push_back(mk(0, 0, 1, 3, 0, 0, 0, 0));
    run_prog();
    check_int("R4", "stall cycles distance 3", cnt_hold_id, 1);

    // Producer already in WB: write-through, no stall.
    prog.push_back(mk(1, 4, 0, 0, 0, 0, 0, 0));
    for (int k = 0; k < 3; k++) prog.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0));
    prog.push_back(mk(0, 0, 1, 4, 0, 0, 0, 0));
    run_prog();
    check_int("R5", "stall cycles producer in WB", cnt_hold_id, 0);

    // Register 0, non-writing producer, disabled source.
    prog.push_back(mk(1, 0, 0, 0, 0, 0, 0, 0));
    prog.push_back(mk(0, 0, 1, 0, 1, 0, 0, 0));
    prog.push_back(mk(0, 5, 0, 0, 0, 0, 0, 0));
    prog.push_back(mk(0, 0, 1, 5, 0, 0, 0, 0));
    prog.push_back(mk(1, 6, 0, 0, 0, 0, 0, 0));
    prog.push_back(mk(0, 0, 0, 6, 0, 6, 0, 0));
    run_prog();
    check_int("R5", "stall cycles for ignored cases", cnt_hold_id, 0);

    // Dependence chain: 3 + 3 stall cycles.
    prog.push_back(mk(1, 7, 0, 0, 0, 0, 0, 0));
    prog.push_back(mk(1, 8, 1, 7, 0, 0, 0, 0));
    prog.push_back(mk(0, 0, 1, 8, 0, 0, 0, 0));
    run_prog();
    check_int("R4", "stall cycles chain", cnt_hold_id, 6);

    // Taken branch: 3 fetch cycles lost, one redirect.
    prog.push_back(mk(0, 0, 0, 0, 0, 0, 1, 1));
    prog.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0));
    run_prog();
    check_int("R7", "pc hold cycles taken", cnt_hold_pc, 3);
    check_int("R6", "redirects taken", cnt_redir, 1);
    check_int("R6", "taken flags", cnt_taken, 1);

    // Not-taken branch: same penalty, no taken flag.
    prog.push_back(mk(0, 0, 0, 0, 0, 0, 1, 0));
    prog.push_back(mk(1, 9, 0, 0, 0, 0, 0, 0));
    prog.push_back(mk(0, 0, 1, 9, 0, 0, 0, 0));
    run_prog();
    check_int("R7", "pc hold cycles not taken", cnt_hold_pc, 3 + 3);
    check_int("R6", "redirects not taken", cnt_redir, 1);
    check_int("R6", "taken flags not taken", cnt_taken, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule